// File: doc/BRIEF.md
# Resumable Memory Pattern Search Engine

This block looks for a byte pattern inside a byte-addressed memory region. Both the pattern and the region live in memory, and the block reaches them through one synchronous read port. The caller gives the address and length of the pattern and the base address and length of the region. Each activate strobe reports the address of the next place where the pattern starts. If the pattern does not occur again, the block reports an all-ones sentinel.

The block keeps a search position between runs. A rewind strobe moves that position back to the start of the region. An activate strobe first loads up to MAX_PAT pattern bytes into an internal buffer. It then compares candidate start positions one byte at a time. After a match, the next search starts one byte after the matched start, so overlapping occurrences are also reported. When the block finishes, done goes high and stays high until the next strobe.

Top module: `pattern_seek`

## Requirements
- R1: While rst_n is low, and in the cycle after it, the outputs are: done=0, busy=0, mem_rd=0 and found=all ones.
- R2: When activate is seen with busy=0 and no rewind strobe, done drops and busy rises on the next cycle. The only exception is an invalid request (R6), which finishes at once instead.
- R3: On a match, found equals blk_addr plus the offset of the lowest candidate start, at or after the search position, where all pat_len region bytes equal the pattern bytes. A match that ends on the last byte of the region is reported.
- R4: After a match at offset k, the next activate continues from offset k+1, so overlapping matches are reported in turn.
- R5: When no candidate matches, found is 0xFFFFFFFF and done is still raised. Every later activate also returns 0xFFFFFFFF until a rewind.
- R6: A request is invalid if pat_len is 0, if pat_len is greater than MAX_PAT (16), or if pat_len is greater than the remaining region length. For an invalid request, done rises on the cycle after the activate with found all ones, and no memory read is issued.
- R7: A rewind strobe takes priority over activate and aborts any search in progress. On the next cycle done=0, busy=0 and found=all ones, and the next search starts at region offset 0.
- R8: Once done is high, done and found hold their values until the next activate or rewind strobe.
- R9: An activate strobe seen while busy=1 is ignored. The search in progress returns its own result, and the search position is not changed.
- R10: Read data on mem_rdata is consumed one cycle after mem_rd. mem_rd is never high on two consecutive cycles. Every read address is inside either the pattern range or the region range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rewind | input | 1 | Strobe: move the search position back to region offset 0 |
| activate | input | 1 | Strobe: find the next match |
| pat_addr | input | ADDR_W | Address of the first pattern byte |
| pat_len | input | PLEN_W | Pattern length in bytes |
| blk_addr | input | ADDR_W | Base address of the searched region |
| blk_len | input | ADDR_W | Region length in bytes |
| mem_addr | output | ADDR_W | Read address |
| mem_rd | output | 1 | Read enable |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| busy | output | 1 | A search is in progress |
| done | output | 1 | The last request has finished; held high as a level |
| found | output | ADDR_W | Match start address, or all ones if there is no match |

## Verification
The bench targets these corner cases:
- It enumerates the worked region until the sentinel appears, and then asks again. A design that forgot its position would report the first match a second time.
- It runs an overlapping pattern. A design that skipped by the pattern length would miss the middle occurrence.
- It searches for a full 16-byte pattern that ends on the last byte of the region, placed after a partial false start. An off-by-one in the fit test or in the index restart would either miss this match or read past the region.
- It covers zero, oversize and overlong lengths, a rewind in the middle of a search, and an activate while busy. A wrong design would read memory it should not read, keep a stale result, or restart the search in the middle.

// File: rtl/pseek_pkg.sv
// Shared types for the pattern search engine.
// Assumes: nothing beyond the enum encoding being free for synthesis.
package pseek_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOAD_REQ = 3'd1,
        ST_LOAD_CAP = 3'd2,
        ST_CMP_REQ  = 3'd3,
        ST_CMP_CHK  = 3'd4
    } seek_state_t;
endpackage

// File: rtl/pseek_patbuf.sv
// Pattern byte buffer: MAX_PAT registered bytes, one write port, one
// combinational read port addressed by index.
// Assumes: the index is below MAX_PAT whenever the write enable is set.
module pseek_patbuf #(
    parameter int MAX_PAT = 16,
    localparam int IDX_W  = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] slot [MAX_PAT];

    for (genvar g = 0; g < MAX_PAT; g++) begin : g_slot
        // Capture one pattern byte into slot g.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g)))
                slot[g] <= wr_data;
        end
    end

    // Select the byte used by the compare step.
    always_comb begin
        rd_data = slot[rd_idx];
    end
endmodule

// File: rtl/pseek_addrgen.sv
// Read address generator: while the pattern loads, it points into the
// pattern; while candidates are compared, it points at region base +
// candidate + index.
// Assumes: the addresses wrap modulo 2**ADDR_W.
module pseek_addrgen #(
    parameter int ADDR_W = 32,
    parameter int PLEN_W = 8
) (
    input  logic              sel_pat,
    input  logic [ADDR_W-1:0] pat_base,
    input  logic [ADDR_W-1:0] blk_base,
    input  logic [ADDR_W-1:0] cand,
    input  logic [PLEN_W-1:0] idx,
    output logic [ADDR_W-1:0] mem_addr
);
    // Choose the pattern or the region address.
    always_comb begin
        if (sel_pat)
            mem_addr = pat_base + ADDR_W'(idx);
        else
            mem_addr = blk_base + cand + ADDR_W'(idx);
    end
endmodule

// File: rtl/pseek_ctrl.sv
// Search sequencer. It holds the resumable position, loads the pattern,
// and steps candidate starts one byte at a time.
// Assumes: the request inputs stay stable from activate until done.
// A rewind strobe overrides everything else.
module pseek_ctrl
    import pseek_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PLEN_W  = 8,
    parameter int MAX_PAT = 16,
    localparam int IDX_W  = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind,
    input  logic              activate,
    input  logic [ADDR_W-1:0] pat_addr,
    input  logic [PLEN_W-1:0] pat_len,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic [ADDR_W-1:0] blk_len,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        pat_byte,
    output logic              mem_rd,
    output logic              sel_pat,
    output logic [ADDR_W-1:0] pat_base,
    output logic [ADDR_W-1:0] blk_base,
    output logic [ADDR_W-1:0] cand,
    output logic [PLEN_W-1:0] idx,
    output logic              buf_wr,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] found
);
    localparam logic [ADDR_W-1:0] NONE = '1;

    seek_state_t       st;
    logic [ADDR_W-1:0] pos;
    logic [ADDR_W-1:0] blen;
    logic [PLEN_W-1:0] plen;
    logic              req_ok;
    logic              last_idx;
    logic              last_cand;
    logic [ADDR_W-1:0] len_ext;

    // Decide whether a fresh request can fit in the rest of the region.
    always_comb begin
        len_ext = ADDR_W'(pat_len);
        req_ok  = (pat_len != '0) && (pat_len <= PLEN_W'(MAX_PAT))
                  && (blk_len >= len_ext) && (pos <= blk_len - len_ext);
    end

    // Flags for the last pattern byte and the last candidate start.
    always_comb begin
        last_idx  = (idx == plen - PLEN_W'(1));
        last_cand = (cand == blen - ADDR_W'(plen));
    end

    // Drive the read port and the buffer from the state.
    always_comb begin
        mem_rd  = (st == ST_LOAD_REQ) || (st == ST_CMP_REQ);
        sel_pat = (st == ST_LOAD_REQ);
        buf_wr  = (st == ST_LOAD_CAP);
        buf_idx = idx[IDX_W-1:0];
        busy    = (st != ST_IDLE);
    end

    // Main sequencer: request intake, pattern load, candidate compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pos      <= '0;
            done     <= 1'b0;
            found    <= NONE;
            idx      <= '0;
            cand     <= '0;
            plen     <= '0;
            blen     <= '0;
            pat_base <= '0;
            blk_base <= '0;
        end else if (rewind) begin
            st    <= ST_IDLE;
            pos   <= '0;
            done  <= 1'b0;
            found <= NONE;
            idx   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (activate) begin
                        if (req_ok) begin
                            done     <= 1'b0;
                            pat_base <= pat_addr;
                            blk_base <= blk_addr;
                            plen     <= pat_len;
                            blen     <= blk_len;
                            cand     <= pos;
                            idx      <= '0;
                            st       <= ST_LOAD_REQ;
                        end else begin
                            done  <= 1'b1;
                            found <= NONE;
                        end
                    end
                end
                ST_LOAD_REQ: st <= ST_LOAD_CAP;
                ST_LOAD_CAP: begin
                    if (last_idx) begin
                        idx <= '0;
                        st  <= ST_CMP_REQ;
                    end else begin
                        idx <= idx + PLEN_W'(1);
                        st  <= ST_LOAD_REQ;
                    end
                end
                ST_CMP_REQ: st <= ST_CMP_CHK;
                ST_CMP_CHK: begin
                    if (mem_rdata == pat_byte) begin
                        if (last_idx) begin
                            found <= blk_base + cand;
                            pos   <= cand + ADDR_W'(1);
                            done  <= 1'b1;
                            st    <= ST_IDLE;
                        end else begin
                            idx <= idx + PLEN_W'(1);
                            st  <= ST_CMP_REQ;
                        end
                    end else begin
                        idx <= '0;
                        if (last_cand) begin
                            found <= NONE;
                            pos   <= blen;
                            done  <= 1'b1;
                            st    <= ST_IDLE;
                        end else begin
                            cand <= cand + ADDR_W'(1);
                            st   <= ST_CMP_REQ;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pattern_seek.sv
// Top level of the resumable pattern search engine. It connects the
// sequencer, the pattern buffer and the read address generator.
// Assumes: the memory returns mem_rdata one cycle after mem_rd and
// accepts a read on any cycle.
module pattern_seek #(
    parameter int ADDR_W  = 32,
    parameter int PLEN_W  = 8,
    parameter int MAX_PAT = 16,
    localparam int IDX_W  = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind,
    input  logic              activate,
    input  logic [ADDR_W-1:0] pat_addr,
    input  logic [PLEN_W-1:0] pat_len,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic [ADDR_W-1:0] blk_len,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] found
);
    logic              sel_pat;
    logic [ADDR_W-1:0] pat_base;
    logic [ADDR_W-1:0] blk_base;
    logic [ADDR_W-1:0] cand;
    logic [PLEN_W-1:0] idx;
    logic              buf_wr;
    logic [IDX_W-1:0]  buf_idx;
    logic [7:0]        pat_byte;

    pseek_ctrl #(.ADDR_W(ADDR_W), .PLEN_W(PLEN_W), .MAX_PAT(MAX_PAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rewind(rewind), .activate(activate),
        .pat_addr(pat_addr), .pat_len(pat_len), .blk_addr(blk_addr),
        .blk_len(blk_len), .mem_rdata(mem_rdata), .pat_byte(pat_byte),
        .mem_rd(mem_rd), .sel_pat(sel_pat), .pat_base(pat_base),
        .blk_base(blk_base), .cand(cand), .idx(idx), .buf_wr(buf_wr),
        .buf_idx(buf_idx), .busy(busy), .done(done), .found(found)
    );

    pseek_patbuf #(.MAX_PAT(MAX_PAT)) u_buf (
        .clk(clk), .wr_en(buf_wr), .wr_idx(buf_idx), .wr_data(mem_rdata),
        .rd_idx(buf_idx), .rd_data(pat_byte)
    );

    pseek_addrgen #(.ADDR_W(ADDR_W), .PLEN_W(PLEN_W)) u_addr (
        .sel_pat(sel_pat), .pat_base(pat_base), .blk_base(blk_base),
        .cand(cand), .idx(idx), .mem_addr(mem_addr)
    );
endmodule

// File: rtl/pseek_checker.sv
// Port-level checks for pattern_seek, attached with bind.
module pseek_checker #(
    parameter int ADDR_W = 32,
    parameter int PLEN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rewind,
    input logic              activate,
    input logic [PLEN_W-1:0] pat_len,
    input logic              mem_rd,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] found
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !busy && !mem_rd && found == '1)); // R1

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (activate && !busy && !rewind) |=> (busy || done)); // R2

    AST_EMPTY_PAT: assert property (@(posedge clk) disable iff (!rst_n)
        (activate && !busy && !rewind && pat_len == '0)
        |=> (done && !busy && found == '1)); // R6

    AST_REWIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (!done && !busy && found == '1)); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !activate && !rewind) |=> (done && $stable(found))); // R8

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R8

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R10
endmodule

bind pattern_seek pseek_checker #(.ADDR_W(ADDR_W), .PLEN_W(PLEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rewind(rewind), .activate(activate),
    .pat_len(pat_len), .mem_rd(mem_rd), .busy(busy), .done(done),
    .found(found)
);

// File: tb/pattern_seek_bench.sv
// Bench for pattern_seek: memory model, behavioural search reference,
// per-clock output comparison and directed scenarios.
module pattern_seek_bench;
    localparam int AW = 32;
    localparam int PW = 8;
    localparam logic [AW-1:0] NONE = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rewind = 1'b0;
    logic          activate = 1'b0;
    logic [AW-1:0] pat_addr = '0;
    logic [PW-1:0] pat_len = '0;
    logic [AW-1:0] blk_addr = '0;
    logic [AW-1:0] blk_len = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_rdata = '0;
    logic          busy;
    logic          done;
    logic [AW-1:0] found;

    logic [7:0] mem [1024];
    int errors = 0;
    int checks = 0;
    longint ref_pos = 0;
    logic [AW-1:0] exp_found = NONE;
    int reads = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pattern_seek u_pattern_seek (
        .clk(clk), .rst_n(rst_n), .rewind(rewind), .activate(activate),
        .pat_addr(pat_addr), .pat_len(pat_len), .blk_addr(blk_addr),
        .blk_len(blk_len), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .found(found)
    );

    // Memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: the next match from ref_pos, given the request.
    function automatic longint ref_find(longint pa, longint pl, longint ba, longint bl);
        if (pl == 0 || pl > 16 || pl > bl || ref_pos > bl - pl) return -1;
        for (longint c = ref_pos; c + pl <= bl; c++) begin
            bit hit = 1;
            for (longint j = 0; j < pl; j++)
                if (mem[(ba + c + j) % 1024] != mem[(pa + j) % 1024]) hit = 0;
            if (hit) return c;
        end
        return -2;
    endfunction

    // Per-clock comparison against the reference state.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(done && busy), "R8 done/busy exclusive", {done, busy}, 0);
            if (done) chk(found == exp_found, "R3/R5 found vs model", found, exp_found);
            if (mem_rd) begin
                reads++;
                chk(((mem_addr >= pat_addr) && (mem_addr < pat_addr + AW'(pat_len))) ||
                    ((mem_addr >= blk_addr) && (mem_addr < blk_addr + blk_len)),
                    "R10 read address in range", mem_addr, blk_addr);
            end
        end
    end

    task automatic do_rewind();
        @(negedge clk); #1;
        rewind = 1'b1; ref_pos = 0; exp_found = NONE;
        @(negedge clk); #1;
        rewind = 1'b0;
    endtask

    // Pulse activate; update the model only when the design is idle.
    task automatic pulse_act(output bit taken);
        @(negedge clk); #1;
        taken = !busy;
        activate = 1'b1;
        if (taken) begin
            longint r = ref_find(pat_addr, pat_len, blk_addr, blk_len);
            if (r >= 0) begin
                exp_found = blk_addr + AW'(r);
                ref_pos = r + 1;
            end else begin
                exp_found = NONE;
                if (r == -2) ref_pos = blk_len;
            end
        end
        @(negedge clk); #1;
        activate = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk); n++;
        end
        chk(done, req, done, 1);
    endtask

    task automatic search(input logic [AW-1:0] pa, input int pl, input logic [AW-1:0] ba,
                          input logic [AW-1:0] bl, input logic [AW-1:0] want, input string req);
        bit t;
        pat_addr = pa; pat_len = PW'(pl); blk_addr = ba; blk_len = bl;
        pulse_act(t);
        wait_done(req);
        @(negedge clk);
        chk(found == want, req, found, want);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit t;
        int r0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
        // Worked example: pattern at 0xFF00, region at 0xFF10 (mapped to 0x300/0x310).
        mem[10'h300] = 101; mem[10'h301] = 102;
        begin
            byte blk [8] = '{99, 100, 101, 102, 103, 101, 102, 100};
            for (int i = 0; i < 8; i++) mem[10'h310 + i] = blk[i];
        end
        // Overlap case.
        mem[10'h100] = 7; mem[10'h101] = 7;
        for (int i = 0; i < 3; i++) mem[10'h110 + i] = 7;
        // Full-width pattern ending on the last region byte, after a false start.
        for (int i = 0; i < 16; i++) mem[10'h200 + i] = 8'(i * 3 + 1);
        for (int i = 0; i < 4; i++) mem[10'h220 + i] = 0;
        mem[10'h222] = 1; mem[10'h223] = 4;
        for (int i = 0; i < 16; i++) mem[10'h224 + i] = 8'(i * 3 + 1);

        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_rd && found == NONE, "R1 reset state", {done, busy, mem_rd}, 0);
        @(negedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && found == NONE, "R1 after reset", found, NONE);

        // R2: a valid activate raises busy on the next cycle.
        pat_addr = 32'hFF00; pat_len = 2; blk_addr = 32'hFF10; blk_len = 8;
        pulse_act(t);
        chk(busy && !done, "R2 busy after activate", {busy, done}, 2);
        wait_done("R3 first match done");
        @(negedge clk);
        chk(found == 32'hFF12, "R3 first match", found, 32'hFF12);
        search(32'hFF00, 2, 32'hFF10, 8, 32'hFF15, "R4 second match");
        search(32'hFF00, 2, 32'hFF10, 8, NONE, "R5 no more matches");
        search(32'hFF00, 2, 32'hFF10, 8, NONE, "R5 sentinel repeats");

        // R8: done and found hold while no strobe arrives.
        repeat (5) @(negedge clk);
        chk(done && found == NONE, "R8 done holds", found, NONE);

        // R7: rewind restarts at the region start.
        do_rewind();
        chk(!done && !busy && found == NONE, "R7 rewind clears", {done, busy}, 0);
        search(32'hFF00, 2, 32'hFF10, 8, 32'hFF12, "R7 rewound search");

        // R4: overlapping matches.
        do_rewind();
        search(32'h100, 2, 32'h110, 3, 32'h110, "R4 overlap first");
        search(32'h100, 2, 32'h110, 3, 32'h111, "R4 overlap second");
        search(32'h100, 2, 32'h110, 3, NONE, "R4 overlap end");

        // R6: invalid lengths finish at once with no reads.
        do_rewind();
        r0 = reads;
        pat_addr = 32'h100; pat_len = 0; blk_addr = 32'h110; blk_len = 3;
        pulse_act(t);
        chk(done && found == NONE, "R6 zero length immediate", found, NONE);
        search(32'h200, 17, 32'h220, 20, NONE, "R6 oversize pattern");
        search(32'h200, 16, 32'h220, 10, NONE, "R6 pattern longer than region");
        chk(reads == r0, "R6 no memory reads", reads, r0);

        // R3: 16-byte match ending on the last region byte.
        search(32'h200, 16, 32'h220, 20, 32'h224, "R3 full pattern at end");
        search(32'h200, 16, 32'h220, 20, NONE, "R5 after end match");

        // R9: activate while busy is ignored.
        do_rewind();
        pat_addr = 32'hFF00; pat_len = 2; blk_addr = 32'hFF10; blk_len = 8;
        pulse_act(t);
        pulse_act(t);
        chk(t == 0, "R9 second strobe while busy", t, 0);
        wait_done("R9 done");
        @(negedge clk);
        chk(found == 32'hFF12, "R9 result unchanged", found, 32'hFF12);
        search(32'hFF00, 2, 32'hFF10, 8, 32'hFF15, "R9 position advanced once");

        // R7: rewind aborts a search in progress.
        do_rewind();
        pulse_act(t);
        do_rewind();
        @(negedge clk);
        chk(!busy && !done, "R7 abort mid-search", {busy, done}, 0);
        search(32'hFF00, 2, 32'hFF10, 8, 32'hFF12, "R7 after abort");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule